// File: doc/BRIEF.md
# Ethernet Receive Deframer with Pad Stripping

This block sits behind the line decoder of a 10 Mb/s Ethernet receiver. It takes the decoded serial bit stream, one bit per clock while the carrier-sense input is high. It skips the start of the preamble and locks onto the start-of-frame delimiter. It then assembles bytes, least significant bit first, and forwards the frame as a byte stream marked with valid and last. While the bytes pass through, it runs the CRC-32 check over every received bit.

When pad stripping is enabled and the big-endian length field in bytes 12 and 13 (counting from 0 after the delimiter) is below 46, only the 14 header bytes and that many data bytes are forwarded. The padding and the FCS are withheld, but the CRC is still checked over the whole frame. A length or type value of 46 or more is never compared with the real size. When carrier drops, a one-cycle status word reports the FCS result, an alignment error, the received byte count, and a discard flag. The discard flag marks frames that are too short or that collided early, so the buffer manager can drop them without host work.

The line cannot be paused, so the byte stream has no ready input: each `out_valid` is a single-cycle pulse and the sink must take it in that cycle. Bytes come at most once per eight clocks, with one exception: the final stripped byte may follow the byte before it in the very next cycle.

Top module: `eth_rx_deframer`

## Requirements
- R1: During and directly after reset, `out_valid`, `out_last` and `eof_valid` are low.
- R2: The first 8 bits after `rx_crs` rises are ignored. After that, the delimiter is found at the first pair of consecutive 1 bits, and the next bit is bit 0 of frame byte 0.
- R3: Each byte is assembled LSB first and forwarded unmodified and in order. Exactly one forwarded byte carries `out_last`, and it is the final forwarded byte of the frame.
- R4: With `strip_en` high and length field {byte12, byte13} below 46, exactly 14 + length bytes are forwarded. This includes length 0, where byte 13 carries `out_last`.
- R5: With `strip_en` low, or a length field of 46 or more, every complete byte after the delimiter is forwarded, FCS included.
- R6: `eof_fcs_err` is 0 when the CRC register run over all received bits, FCS included, ends at 0xC704DD7B, and 1 otherwise. This also holds when stripping withheld bytes.
- R7: `eof_count` gives the number of complete bytes received after the delimiter, including any bytes that were stripped.
- R8: `eof_discard` is 1 when fewer than 64 bytes were received.
- R9: `eof_discard` is 1 when `rx_col` is high during a frame bit while fewer than 64 bytes have completed. A collision after 64 bytes does not set it.
- R10: `eof_align_err` is 1 when the frame ends with a partial byte. The partial bits are not forwarded.
- R11: `eof_valid` pulses for one cycle, one clock after `rx_crs` falls, and only for frames that reached the delimiter. A carrier loss during the preamble produces neither bytes nor status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one line bit per cycle while carrier is up |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_crs | input | 1 | Carrier valid; high while decoded bits are present |
| rx_bit | input | 1 | Decoded serial data bit |
| rx_col | input | 1 | Collision indication |
| strip_en | input | 1 | Enable removal of padding and FCS by length field |
| out_valid | output | 1 | Single-cycle byte strobe |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Marks the final forwarded byte of the frame |
| eof_valid | output | 1 | Single-cycle end-of-frame status strobe |
| eof_fcs_err | output | 1 | CRC residue mismatch |
| eof_discard | output | 1 | Frame short or collided early; delete it |
| eof_align_err | output | 1 | Frame ended on a partial byte |
| eof_count | output | CNT_W | Complete bytes received after the delimiter |

## Verification
The hardest case to reach from the ports is stripping with a length of zero. There the length byte itself has to become the last byte, and it is emitted in the cycle right after the byte before it, while the rest of the frame still arrives and must still go into the CRC. The table-driven frames reach this case and its neighbours, lengths 0, 10, 20, 45 and 46, by building the header in the bench and appending an FCS computed with the reflected byte-wise CRC. Collisions are placed on the first bit of byte 63 and of byte 64 to hit both sides of the discard boundary. A directed preamble starts with eight 1 bits, which would trigger a false lock if the skip window were short.

// File: rtl/rxdf_pkg.sv
package rxdf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SKIP,
    ST_HUNT,
    ST_DATA
  } rx_state_e;

  localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;
endpackage

// File: rtl/rxdf_sync.sv
module rxdf_sync
  import rxdf_pkg::*;
#(
  parameter int SKIP_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic crs_i,
  input  logic bit_i,
  output logic data_en_o,
  output logic sfd_o,
  output logic end_o
);
  localparam int SKW = $clog2(SKIP_BITS + 1);

  rx_state_e      state;
  logic [SKW-1:0] skip_cnt;
  logic           prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      skip_cnt <= '0;
      prev     <= 1'b0;
    end else if (!crs_i) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          skip_cnt <= SKW'(1);
          prev     <= 1'b0;
          state    <= (SKIP_BITS <= 1) ? ST_HUNT : ST_SKIP;
        end
        ST_SKIP: begin
          if (skip_cnt == SKW'(SKIP_BITS - 1)) begin
            state <= ST_HUNT;
            prev  <= 1'b0;
          end else begin
            skip_cnt <= skip_cnt + 1'b1;
          end
        end
        ST_HUNT: begin
          prev <= bit_i;
          if (prev && bit_i) state <= ST_DATA;
        end
        default: ;
      endcase
    end
  end

  assign data_en_o = crs_i && (state == ST_DATA);
  assign sfd_o     = crs_i && (state == ST_HUNT) && prev && bit_i;
  assign end_o     = !crs_i && (state == ST_DATA);
endmodule

// File: rtl/rxdf_crc.sv
module rxdf_crc
  import rxdf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic en_i,
  input  logic bit_i,
  output logic ok_o
);
  logic [31:0] crc_q;
  logic        fb;

  assign fb = crc_q[31] ^ bit_i;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      crc_q <= '1;
    end else if (en_i) begin
      crc_q <= {crc_q[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
  end

  assign ok_o = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/rxdf_assemble.sv
module rxdf_assemble #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic             byte_done_o,
  output logic [7:0]       byte_o,
  output logic [CNT_W-1:0] count_o,
  output logic [2:0]       phase_o
);
  logic [6:0] sr;

  assign byte_done_o = en_i && (phase_o == 3'd7);
  assign byte_o      = {bit_i, sr};

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      sr      <= '0;
      phase_o <= '0;
      count_o <= '0;
    end else if (en_i) begin
      sr      <= {bit_i, sr[6:1]};
      phase_o <= phase_o + 3'd1;
      if (byte_done_o && (count_o != '1)) count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/eth_rx_deframer.sv
module eth_rx_deframer #(
  parameter int CNT_W     = 16,
  parameter int MIN_FRAME = 64,
  parameter int MIN_DATA  = 46,
  parameter int HDR_LEN   = 14,
  parameter int SKIP_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_crs,
  input  logic             rx_bit,
  input  logic             rx_col,
  input  logic             strip_en,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             eof_valid,
  output logic             eof_fcs_err,
  output logic             eof_discard,
  output logic             eof_align_err,
  output logic [CNT_W-1:0] eof_count
);
  localparam int LEN_HI = HDR_LEN - 2;
  localparam int LEN_LO = HDR_LEN - 1;

  logic             data_en, sfd_hit, frame_end;
  logic             byte_done, crc_ok;
  logic [7:0]       cur_byte;
  logic [CNT_W-1:0] idx;
  logic [2:0]       phase;

  rxdf_sync #(.SKIP_BITS(SKIP_BITS)) sync_i (
    .clk(clk), .rst_n(rst_n), .crs_i(rx_crs), .bit_i(rx_bit),
    .data_en_o(data_en), .sfd_o(sfd_hit), .end_o(frame_end)
  );

  rxdf_assemble #(.CNT_W(CNT_W)) asm_i (
    .clk(clk), .rst_n(rst_n), .clear_i(sfd_hit), .en_i(data_en),
    .bit_i(rx_bit), .byte_done_o(byte_done), .byte_o(cur_byte),
    .count_o(idx), .phase_o(phase)
  );

  rxdf_crc crc_i (
    .clk(clk), .rst_n(rst_n), .clear_i(sfd_hit), .en_i(data_en),
    .bit_i(rx_bit), .ok_o(crc_ok)
  );

  logic [7:0]       held, len_hi;
  logic             held_v, stopped, flush_pend, lim_v, col_seen;
  logic [CNT_W-1:0] lim;
  logic [15:0]      len_now;
  logic             cut_now, hit_limit, do_flush;

  assign len_now   = {len_hi, cur_byte};
  assign cut_now   = byte_done && strip_en && (idx == CNT_W'(LEN_LO))
                     && (len_now < 16'(MIN_DATA));
  assign hit_limit = byte_done && !stopped &&
                     ((cut_now && (len_now == 16'd0)) || (lim_v && (idx == lim)));
  assign do_flush  = (flush_pend || frame_end) && held_v && !stopped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_last      <= 1'b0;
      eof_valid     <= 1'b0;
      eof_fcs_err   <= 1'b0;
      eof_discard   <= 1'b0;
      eof_align_err <= 1'b0;
      eof_count     <= '0;
      held          <= '0;
      held_v        <= 1'b0;
      stopped       <= 1'b0;
      flush_pend    <= 1'b0;
      len_hi        <= '0;
      lim           <= '0;
      lim_v         <= 1'b0;
      col_seen      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      eof_valid <= 1'b0;

      if (sfd_hit) begin
        held_v     <= 1'b0;
        stopped    <= 1'b0;
        flush_pend <= 1'b0;
        lim_v      <= 1'b0;
        col_seen   <= 1'b0;
      end

      if (data_en && rx_col && (idx < CNT_W'(MIN_FRAME))) col_seen <= 1'b1;

      if (byte_done && !stopped) begin
        if (held_v) begin
          out_valid <= 1'b1;
          out_data  <= held;
        end
        held   <= cur_byte;
        held_v <= 1'b1;
        if (idx == CNT_W'(LEN_HI)) len_hi <= cur_byte;
        if (cut_now) begin
          lim   <= CNT_W'(LEN_LO) + CNT_W'(len_now);
          lim_v <= 1'b1;
        end
        if (hit_limit) flush_pend <= 1'b1;
      end

      if (do_flush) begin
        out_valid  <= 1'b1;
        out_last   <= 1'b1;
        out_data   <= held;
        held_v     <= 1'b0;
        stopped    <= 1'b1;
        flush_pend <= 1'b0;
      end

      if (frame_end) begin
        eof_valid     <= 1'b1;
        eof_fcs_err   <= !crc_ok;
        eof_align_err <= (phase != 3'd0);
        eof_count     <= idx;
        eof_discard   <= col_seen || (idx < CNT_W'(MIN_FRAME));
        held_v        <= 1'b0;
        flush_pend    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eth_rx_deframer_chk.sv
module eth_rx_deframer_chk #(
  parameter int CNT_W     = 16,
  parameter int MIN_FRAME = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_crs,
  input logic             out_valid,
  input logic             out_last,
  input logic             eof_valid,
  input logic             eof_discard,
  input logic [CNT_W-1:0] eof_count
);
  a_r3_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r3_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> !out_valid);

  a_r11_eof_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eof_valid |=> !eof_valid);

  a_r11_eof_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    eof_valid |-> !$past(rx_crs));

  a_r8_short_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_valid && (eof_count < CNT_W'(MIN_FRAME))) |-> eof_discard);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_crs && !$past(rx_crs) && !$past(rx_crs, 2)) |-> !out_valid);
endmodule

bind eth_rx_deframer eth_rx_deframer_chk #(.CNT_W(CNT_W), .MIN_FRAME(MIN_FRAME)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_crs(rx_crs), .out_valid(out_valid),
  .out_last(out_last), .eof_valid(eof_valid), .eof_discard(eof_discard),
  .eof_count(eof_count)
);

// File: tb/eth_rx_deframer_tb_top.sv
module eth_rx_deframer_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_crs = 1'b0, rx_bit = 1'b0, rx_col = 1'b0, strip_en = 1'b0;
  logic out_valid, out_last, eof_valid, eof_fcs_err, eof_discard, eof_align_err;
  logic [7:0] out_data;
  logic [CNT_W-1:0] eof_count;

  always #5 clk = ~clk;

  eth_rx_deframer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_crs(rx_crs), .rx_bit(rx_bit), .rx_col(rx_col),
    .strip_en(strip_en), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .eof_valid(eof_valid), .eof_fcs_err(eof_fcs_err),
    .eof_discard(eof_discard), .eof_align_err(eof_align_err), .eof_count(eof_count)
  );

  typedef struct packed {
    logic [7:0]  ndata;
    logic [15:0] lenf;
    logic        strip;
    logic        bad;
    logic [7:0]  colb;
    logic [2:0]  extra;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [0:NV-1] = '{
    '{8'd46,  16'd46,     1'b1, 1'b0, 8'hFF, 3'd0},
    '{8'd46,  16'd10,     1'b1, 1'b0, 8'hFF, 3'd0},
    '{8'd46,  16'd10,     1'b0, 1'b0, 8'hFF, 3'd0},
    '{8'd46,  16'd0,      1'b1, 1'b0, 8'hFF, 3'd0},
    '{8'd100, 16'h0800,   1'b1, 1'b0, 8'hFF, 3'd0},
    '{8'd46,  16'd20,     1'b1, 1'b1, 8'hFF, 3'd0},
    '{8'd20,  16'd20,     1'b0, 1'b0, 8'hFF, 3'd0},
    '{8'd46,  16'd46,     1'b0, 1'b0, 8'd30, 3'd0},
    '{8'd60,  16'd60,     1'b0, 1'b0, 8'd64, 3'd0},
    '{8'd46,  16'd46,     1'b0, 1'b0, 8'hFF, 3'd3},
    '{8'd46,  16'd45,     1'b1, 1'b0, 8'hFF, 3'd0},
    '{8'd50,  16'd50,     1'b0, 1'b0, 8'd63, 3'd0}
  };

  int nchecks = 0, nerrs = 0;
  logic [7:0] tx [0:255];
  int tx_n;
  logic [7:0] got [0:255];
  int got_n = 0, last_n = 0, last_pos = -1;
  int eof_n = 0;
  logic e_fcs, e_disc, e_align;
  int e_cnt;

  always @(negedge clk) begin
    if (out_valid) begin
      got[got_n[7:0]] = out_data;
      if (out_last) begin last_n++; last_pos = got_n; end
      got_n++;
    end
    if (eof_valid) begin
      eof_n++; e_fcs = eof_fcs_err; e_disc = eof_discard;
      e_align = eof_align_err; e_cnt = int'(eof_count);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerrs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mon_clear();
    got_n = 0; last_n = 0; last_pos = -1; eof_n = 0;
  endtask

  task automatic drive_bit(input logic b, input logic c);
    @(negedge clk);
    rx_crs = 1'b1; rx_bit = b; rx_col = c;
  endtask

  task automatic drive_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) drive_bit(v[i], 1'b0);
  endtask

  task automatic build(input vec_t v);
    logic [31:0] crc;
    tx_n = 14 + int'(v.ndata);
    for (int i = 0; i < 6; i++) tx[i] = 8'h10 + 8'(i);
    for (int i = 6; i < 12; i++) tx[i] = 8'hA0 + 8'(i);
    tx[12] = v.lenf[15:8];
    tx[13] = v.lenf[7:0];
    for (int i = 14; i < tx_n; i++) tx[i] = 8'(i * 7 + 3);
    crc = 32'hFFFF_FFFF;
    for (int i = 0; i < tx_n; i++) begin
      crc = crc ^ {24'h0, tx[i]};
      for (int k = 0; k < 8; k++)
        crc = crc[0] ? ((crc >> 1) ^ 32'hEDB8_8320) : (crc >> 1);
    end
    crc = ~crc;
    for (int k = 0; k < 4; k++) tx[tx_n + k] = crc[8*k +: 8];
    tx_n += 4;
    if (v.bad) tx[20] = tx[20] ^ 8'h04;
  endtask

  task automatic send(input int pre_kind, input int colb, input int extra);
    if (pre_kind == 0) begin
      for (int i = 0; i < 7; i++) drive_byte(8'h55);
    end else begin
      for (int i = 0; i < 8; i++) drive_bit(1'b1, 1'b0);
      drive_byte(8'h55); drive_byte(8'h55);
    end
    drive_byte(8'hD5);
    for (int i = 0; i < tx_n; i++)
      for (int k = 0; k < 8; k++) drive_bit(tx[i][k], (i == colb) && (k == 0));
    for (int k = 0; k < extra; k++) drive_bit(1'b1, 1'b0);
    @(negedge clk);
    rx_crs = 1'b0; rx_col = 1'b0; rx_bit = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic check_bytes(input int exp_n, input string req);
    int bad = 0;
    for (int i = 0; i < exp_n && i < got_n; i++) if (got[i] != tx[i]) bad++;
    chk(got_n == exp_n, req, "forwarded byte count", got_n, exp_n);
    chk(bad == 0, "R3", "byte mismatches", bad, 0);
    chk(last_n == 1 && last_pos == exp_n - 1, "R3", "last position", last_pos, exp_n - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!out_valid && !out_last && !eof_valid, "R1", "outputs in reset",
        int'({out_valid, out_last, eof_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !out_last && !eof_valid, "R1", "outputs after reset",
        int'({out_valid, out_last, eof_valid}), 0);

    for (int n = 0; n < NV; n++) begin
      vec_t v = VECS[n];
      bit cut = v.strip && (v.lenf < 16'd46);
      int exp_n;
      build(v);
      exp_n = cut ? ((14 + int'(v.lenf)) < tx_n ? 14 + int'(v.lenf) : tx_n) : tx_n;
      strip_en = v.strip;
      mon_clear();
      send(0, (v.colb == 8'hFF) ? -1 : int'(v.colb), int'(v.extra));
      check_bytes(exp_n, cut ? "R4" : "R5");
      chk(eof_n == 1, "R11", "status pulses", eof_n, 1);
      chk(e_cnt == tx_n, "R7", "byte count", e_cnt, tx_n);
      if (v.extra == 0)
        chk(e_fcs == v.bad, "R6", "fcs error", int'(e_fcs), int'(v.bad));
      chk(e_align == (v.extra != 0), "R10", "align error", int'(e_align), int'(v.extra != 0));
      if (v.colb != 8'hFF)
        chk(e_disc == (v.colb < 8'd64), "R9", "collision discard", int'(e_disc),
            int'(v.colb < 8'd64));
      else
        chk(e_disc == (tx_n < 64), "R8", "short discard", int'(e_disc), int'(tx_n < 64));
    end

    // R2: eight leading 1 bits must fall inside the skip window
    build(VECS[0]);
    strip_en = 1'b0;
    mon_clear();
    send(1, -1, 0);
    check_bytes(tx_n, "R2");
    chk(e_fcs == 1'b0, "R2", "fcs after long skip", int'(e_fcs), 0);

    // R11: carrier lost inside the preamble gives nothing
    mon_clear();
    for (int i = 0; i < 12; i++) drive_bit(i[0] ? 1'b0 : 1'b1, 1'b0);
    @(negedge clk);
    rx_crs = 1'b0;
    repeat (10) @(negedge clk);
    chk(got_n == 0, "R11", "bytes from aborted preamble", got_n, 0);
    chk(eof_n == 0, "R11", "status from aborted preamble", eof_n, 0);

    $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++; nerrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end
endmodule